// File: doc/BRIEF.md
# RS-485 Driver-Enable Sequencer

This block drives the direction control of an RS-485 transceiver that sits beside a UART working half duplex. The transmitter sends it a strobe when a character begins and a strobe when the stop bit of the last queued character has finished. The sequencer then turns the line driver on before any data bit reaches the wire and turns it off again when the frame is complete. A programmable number of whole bit times can be added as a turnaround margin so that long cables settle before the driver releases the bus. It also has a polarity select for transceivers whose enable is active low, and a receive-blanking output that masks the local receiver while the UART is sending, so that the block does not hear its own echo.

The turnaround margin is counted on a bit-time tick supplied by the baud generator. A character that starts while the margin is still running cancels the count and keeps the driver on without a gap. Baud generation, serialization and pin multiplexing are handled elsewhere.

Top module: `rs485_de_seq`

## Requirements
- R1: While reset is asserted and right after it, `de_pin` equals `de_invert` (driver inactive) and `rx_gate` is 0.
- R2: With `rs485_en` high, a `tx_start` pulse makes the driver active from the next clock cycle, and it stays active until the end-of-frame sequence of R3 or R4 completes. The transmitter starts its first bit no earlier than that cycle.
- R3: If `turn_delay` is 0 when `tx_done` is seen while driving, the driver is inactive from the next cycle.
- R4: If `turn_delay` is N in 1..15 when `tx_done` is seen while driving, the driver stays active through N `bit_tick` pulses that occur after the `tx_done` cycle and is inactive from the cycle after the N-th tick. The delay value is sampled in the `tx_done` cycle. A tick in that same cycle is not counted.
- R5: A `tx_start` during the turnaround count cancels the count and keeps the driver active with no inactive cycle. A later `tx_done` starts a fresh count from the then-current `turn_delay`.
- R6: `de_pin` is the internal active level XOR `de_invert`: with `de_invert`=0 the driver is on when `de_pin` is 1, and with `de_invert`=1 it is on when `de_pin` is 0.
- R7: While `rs485_en` is 0, `de_pin` equals `de_invert` in the same cycle, `tx_start` is ignored and any turnaround count is abandoned.
- R8: With `hd_en` at 1, `rx_gate` is 1 from the cycle after `tx_start` up to and including the cycle of the `tx_done` that ends the transmission, whatever the value of `rs485_en`. With `hd_en` at 0, `rx_gate` is 0.
- R9: When `tx_start` and `tx_done` arrive in the same cycle, the start takes priority: the driver stays active and no turnaround count begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rs485_en | input | 1 | Enables automatic direction control |
| hd_en | input | 1 | Enables receive blanking during transmission |
| de_invert | input | 1 | 1 selects an active-low driver enable |
| turn_delay | input | DLY_W (4) | Extra bit times to hold the driver after the last stop bit |
| tx_start | input | 1 | Pulse: a character is starting |
| tx_done | input | 1 | Pulse: the last stop bit of the last queued character has ended |
| bit_tick | input | 1 | Pulse once per bit time |
| de_pin | output | 1 | Driver-enable pin level |
| rx_gate | output | 1 | 1 masks the receiver |

## Verification
The hardest case to reach is a new character that arrives in the middle of a turnaround count, especially on the same cycle as the tick that would have ended the count, or together with a done strobe. Directed sequences set up a long delay, let a few ticks pass and then inject a start, including one that lands on the final tick. A long run of seeded random strobes, ticks and delay values then repeatedly produces overlaps of start, done and tick, with rare toggles of enable and polarity. Each of these cycles is compared with a bench model built from the requirements.

// File: rtl/rs485_de_pkg.sv
package rs485_de_pkg;
   typedef enum logic [1:0] {
      DE_IDLE  = 2'd0,
      DE_DRIVE = 2'd1,
      DE_HOLD  = 2'd2
   } de_state_t;
endpackage

// File: rtl/rs485_de_txtrack.sv
// Tracks whether the transmitter is between a character start and
// the end of its last stop bit; used for receive blanking.
module rs485_de_txtrack (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic done_i,
   output logic busy_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)       busy_o <= 1'b0;
      else if (start_i) busy_o <= 1'b1;
      else if (done_i)  busy_o <= 1'b0;
   end
endmodule

// File: rtl/rs485_de_turncnt.sv
// Down-counter for the turnaround margin in bit times.
module rs485_de_turncnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic [W-1:0] cnt_o,
   output logic         last_o
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_o <= '0;
      else if (clr_i)  cnt_o <= '0;
      else if (load_i) cnt_o <= load_val_i;
      else if (dec_i)  cnt_o <= cnt_o - ONE;
   end

   assign last_o = (cnt_o == ONE);
endmodule

// File: rtl/rs485_de_ctrl.sv
// Direction state machine: idle, driving a frame, holding for turnaround.
module rs485_de_ctrl
   import rs485_de_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic         start_i,
   input  logic         done_i,
   input  logic         tick_i,
   input  logic [W-1:0] delay_i,
   input  logic         cnt_last_i,
   output logic         cnt_clr_o,
   output logic         cnt_load_o,
   output logic         cnt_dec_o,
   output de_state_t    st_o,
   output logic         active_o
);
   de_state_t st_q, st_d;

   always_comb begin
      st_d       = st_q;
      cnt_clr_o  = 1'b0;
      cnt_load_o = 1'b0;
      cnt_dec_o  = 1'b0;
      if (!en_i) begin
         st_d      = DE_IDLE;
         cnt_clr_o = 1'b1;
      end else begin
         unique case (st_q)
            DE_IDLE: begin
               if (start_i) st_d = DE_DRIVE;
            end
            DE_DRIVE: begin
               if (!start_i && done_i) begin
                  if (delay_i == '0) begin
                     st_d = DE_IDLE;
                  end else begin
                     st_d       = DE_HOLD;
                     cnt_load_o = 1'b1;
                  end
               end
            end
            DE_HOLD: begin
               if (start_i) begin
                  st_d      = DE_DRIVE;
                  cnt_clr_o = 1'b1;
               end else if (tick_i) begin
                  if (cnt_last_i) begin
                     st_d      = DE_IDLE;
                     cnt_clr_o = 1'b1;
                  end else begin
                     cnt_dec_o = 1'b1;
                  end
               end
            end
            default: begin
               st_d      = DE_IDLE;
               cnt_clr_o = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= DE_IDLE;
      else        st_q <= st_d;
   end

   assign st_o     = st_q;
   assign active_o = (st_q != DE_IDLE);
endmodule

// File: rtl/rs485_de_seq.sv
module rs485_de_seq
   import rs485_de_pkg::*;
#(
   parameter int DLY_W    = 4,
   parameter bit OUT_FLOP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rs485_en,
   input  logic             hd_en,
   input  logic             de_invert,
   input  logic [DLY_W-1:0] turn_delay,
   input  logic             tx_start,
   input  logic             tx_done,
   input  logic             bit_tick,
   output logic             de_pin,
   output logic             rx_gate
);
   localparam int MAX_DLY = (1 << DLY_W) - 1;

   generate
      if (DLY_W < 1 || DLY_W > 8) begin : g_bad_width
         $error("rs485_de_seq: DLY_W must be 1..8");
      end
      if (MAX_DLY < 1) begin : g_bad_range
         $error("rs485_de_seq: delay range empty");
      end
   endgenerate

   logic             cnt_clr, cnt_load, cnt_dec, cnt_last;
   logic [DLY_W-1:0] cnt_q;
   de_state_t        st_q;
   logic             de_active;
   logic             tx_busy;
   logic             pin_level;

   rs485_de_ctrl #(.W(DLY_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (rs485_en),
      .start_i    (tx_start),
      .done_i     (tx_done),
      .tick_i     (bit_tick),
      .delay_i    (turn_delay),
      .cnt_last_i (cnt_last),
      .cnt_clr_o  (cnt_clr),
      .cnt_load_o (cnt_load),
      .cnt_dec_o  (cnt_dec),
      .st_o       (st_q),
      .active_o   (de_active)
   );

   rs485_de_turncnt #(.W(DLY_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (cnt_clr),
      .load_i     (cnt_load),
      .load_val_i (turn_delay),
      .dec_i      (cnt_dec),
      .cnt_o      (cnt_q),
      .last_o     (cnt_last)
   );

   rs485_de_txtrack u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (tx_start),
      .done_i  (tx_done),
      .busy_o  (tx_busy)
   );

   assign pin_level = (rs485_en & de_active) ^ de_invert;

   generate
      if (OUT_FLOP) begin : g_out_reg
         logic pin_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pin_q <= de_invert;
            else        pin_q <= pin_level;
         end
         assign de_pin = pin_q;
      end else begin : g_out_comb
         assign de_pin = pin_level;
      end
   endgenerate

   assign rx_gate = hd_en & tx_busy;
endmodule

// File: rtl/rs485_de_seq_chk.sv
module rs485_de_seq_chk
   import rs485_de_pkg::*;
#(
   parameter int DLY_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rs485_en,
   input logic             hd_en,
   input logic             tx_start,
   input logic             tx_done,
   input logic             bit_tick,
   input logic [DLY_W-1:0] turn_delay,
   input logic [DLY_W-1:0] cnt_q,
   input de_state_t        st_q,
   input logic             rx_gate
);
   assert_start_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rs485_en && tx_start) |=> (!rs485_en || st_q == DE_DRIVE));

   assert_zero_delay_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rs485_en && st_q == DE_DRIVE && tx_done && !tx_start && turn_delay == '0)
      |=> (st_q == DE_IDLE));

   assert_hold_waits_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rs485_en && st_q == DE_HOLD && !bit_tick && !tx_start)
      |=> (st_q == DE_HOLD && $stable(cnt_q)));

   assert_hold_loads_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rs485_en && st_q == DE_DRIVE && tx_done && !tx_start && turn_delay != '0)
      |=> (st_q == DE_HOLD && cnt_q == $past(turn_delay)));

   assert_cancel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rs485_en && st_q == DE_HOLD && tx_start) |=> (st_q == DE_DRIVE));

   assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rs485_en) |=> (st_q == DE_IDLE));

   assert_gate_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hd_en && tx_start) |=> (!hd_en || rx_gate));

   assert_start_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rs485_en && st_q == DE_DRIVE && tx_start && tx_done) |=> (st_q == DE_DRIVE));
endmodule

bind rs485_de_seq rs485_de_seq_chk #(.DLY_W(DLY_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rs485_en   (rs485_en),
   .hd_en      (hd_en),
   .tx_start   (tx_start),
   .tx_done    (tx_done),
   .bit_tick   (bit_tick),
   .turn_delay (turn_delay),
   .cnt_q      (cnt_q),
   .st_q       (st_q),
   .rx_gate    (rx_gate)
);

// File: tb/rs485_de_seq_test.sv
module rs485_de_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rs485_en = 1'b0;
   logic       hd_en = 1'b0;
   logic       de_invert = 1'b0;
   logic [3:0] turn_delay = 4'd0;
   logic       tx_start = 1'b0;
   logic       tx_done = 1'b0;
   logic       bit_tick = 1'b0;
   logic       de_pin;
   logic       rx_gate;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   rs485_de_seq uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .rs485_en   (rs485_en),
      .hd_en      (hd_en),
      .de_invert  (de_invert),
      .turn_delay (turn_delay),
      .tx_start   (tx_start),
      .tx_done    (tx_done),
      .bit_tick   (bit_tick),
      .de_pin     (de_pin),
      .rx_gate    (rx_gate)
   );

   // Reference model written from the requirements.
   bit m_act = 0, m_hold = 0, m_busy = 0;
   int m_cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act <= 0; m_hold <= 0; m_cnt <= 0; m_busy <= 0;
      end else begin
         if (tx_start)     m_busy <= 1;
         else if (tx_done) m_busy <= 0;
         if (!rs485_en) begin
            m_act <= 0; m_hold <= 0;
         end else if (tx_start) begin
            m_act <= 1; m_hold <= 0;
         end else if (m_act && !m_hold && tx_done) begin
            if (turn_delay == 0) m_act <= 0;
            else begin m_hold <= 1; m_cnt <= int'(turn_delay); end
         end else if (m_hold && bit_tick) begin
            if (m_cnt == 1) begin m_act <= 0; m_hold <= 0; end
            else m_cnt <= m_cnt - 1;
         end
      end
   end

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_check();
      string tag;
      if (!rs485_en)      tag = "R7";
      else if (m_hold)    tag = "R4";
      else if (de_invert) tag = "R6";
      else                tag = "R2";
      chk(tag, de_pin, (rs485_en & m_act) ^ de_invert);
      chk("R8", rx_gate, hd_en & m_busy);
   endtask

   task automatic step(bit s, bit d, bit t);
      tx_start = s; tx_done = d; bit_tick = t;
      @(negedge clk);
      model_check();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0);
   endtask

   task automatic run_all();
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", de_pin, 1'b0);
      chk("R1", rx_gate, 1'b0);
      rst_n = 1; rs485_en = 1; hd_en = 1;
      step(0, 0, 1);
      chk("R1", de_pin, 1'b0);

      // R2/R3: zero delay
      turn_delay = 0;
      step(1, 0, 0);
      chk("R2", de_pin, 1'b1);
      chk("R8", rx_gate, 1'b1);
      step(0, 0, 1); step(0, 0, 1);
      step(0, 1, 1);
      chk("R3", de_pin, 1'b0);
      chk("R8", rx_gate, 1'b0);
      idle(2);

      // R4: delay 3, tick in done cycle not counted
      turn_delay = 3;
      step(1, 0, 0); step(0, 0, 1);
      step(0, 1, 1);
      turn_delay = 9;
      step(0, 0, 1); chk("R4", de_pin, 1'b1);
      step(0, 0, 0); step(0, 0, 1); chk("R4", de_pin, 1'b1);
      step(0, 0, 1); chk("R4", de_pin, 1'b0);
      idle(2);

      // R5: start on the final tick of the count, then fresh count
      turn_delay = 2;
      step(1, 0, 0); step(0, 1, 0);
      step(0, 0, 1);
      step(1, 0, 1); chk("R5", de_pin, 1'b1);
      turn_delay = 1;
      step(0, 0, 1); chk("R5", de_pin, 1'b1);
      step(0, 1, 0); step(0, 0, 0); chk("R5", de_pin, 1'b1);
      step(0, 0, 1); chk("R5", de_pin, 1'b0);
      idle(2);

      // R9: start and done together
      turn_delay = 0;
      step(1, 0, 0); step(1, 1, 0);
      chk("R9", de_pin, 1'b1);
      step(0, 0, 0); chk("R9", de_pin, 1'b1);
      step(0, 1, 0); chk("R3", de_pin, 1'b0);

      // R6: inverted polarity
      de_invert = 1; turn_delay = 1;
      step(0, 0, 0); chk("R6", de_pin, 1'b1);
      step(1, 0, 0); chk("R6", de_pin, 1'b0);
      step(0, 1, 0); step(0, 0, 1); chk("R6", de_pin, 1'b1);
      de_invert = 0;

      // R7: disabled ignores start; R8 still blanks
      rs485_en = 0; hd_en = 1;
      step(1, 0, 0); chk("R7", de_pin, 1'b0); chk("R8", rx_gate, 1'b1);
      step(0, 1, 0); chk("R8", rx_gate, 1'b0);
      rs485_en = 1; turn_delay = 4;
      step(1, 0, 0); step(0, 1, 0); step(0, 0, 1);
      rs485_en = 0; de_invert = 1;
      step(0, 0, 0); chk("R7", de_pin, 1'b1);
      rs485_en = 1;
      step(0, 0, 0); chk("R7", de_pin, 1'b1);
      de_invert = 0; hd_en = 0;
      step(1, 0, 0); chk("R8", rx_gate, 1'b0);
      step(0, 1, 0);

      // Random phase
      void'($urandom(32'd4242));
      hd_en = 1;
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(199) == 0) de_invert = ~de_invert;
         if ($urandom_range(99) == 0)  hd_en = ~hd_en;
         rs485_en   = ($urandom_range(39) != 0);
         turn_delay = 4'($urandom_range(15));
         step($urandom_range(19) == 0, $urandom_range(5) == 0,
              $urandom_range(2) == 0);
      end
   endtask

   initial begin
      bit timeout = 0;
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            timeout = 1;
         end
      join_any
      disable fork;
      if (timeout) begin
         checks++; errors++;
         $display("FAIL watchdog actual timeout expected completion");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule